// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA over the target's slave SPI port. A single start pulse runs the whole sequence. The block pulls the target's active-low reset and its SPI select low together. It releases reset after a timed pulse and checks that the target's done flag has cleared. It then keeps select low for a long housekeeping interval and releases select. After that it streams the image bytes as an SPI mode-0 master.

When the byte stream's last marker has been consumed, the block checks that the done flag has risen. It then clocks out a run of zero bytes that brings the loaded design to life. The result is reported on busy, ok and error status lines, with a two-bit code that tells the error causes apart. A request for partial reconfiguration is refused without moving any target pin.

Image bytes come from an upstream byte stream with valid, ready and last. The block takes a byte only when its shifter is empty, so the source sets the pace and no buffering is needed inside.

Top module: `cfg_loader`

## Requirements
- R1: A start with partial mode off drives the target reset low and the target select low on the same clock edge. Reset stays low for RST_US microseconds, counted as (CLK_HZ/1e6)*RST_US system clocks (50 clocks with the default values). Reset is never low while select is high.
- R2: After reset is released, the synchronized done flag is checked. If it reads high, the block enters the error state with code 1 (reset stuck). Select is released, and no serial clock edge is produced.
- R3: After reset is released, select stays low for at least HK_US microseconds of housekeeping. No serial clock runs during that time. Select then goes high for at least one system clock before the first serial clock edge.
- R4: The serial link is mode 0. The clock idles low and toggles only while select is low. Each clock phase lasts SCK_HALF system clocks. MOSI changes only while the clock is low. A serial rate outside 1 MHz to 25 MHz is rejected at elaboration.
- R5: Image bytes are shifted most significant bit first. s_ready_o is high only while streaming with an empty shifter. Each accepted byte appears exactly once on MOSI, in order.
- R6: After the byte flagged last has been shifted out, the done flag must read high. Otherwise the block enters the error state with code 2 (not done), and no padding clocks are sent.
- R7: Once done is confirmed, PAD_BYTES zero bytes are shifted out (56 clocks with the default of 7, at least the 49 that are needed). The block then reports ok_o high with code 0.
- R8: A start with partial_i high enters the error state with code 3 (partial refused). Target reset and select stay high throughout.
- R9: Start is acted on only in idle, ok or error. In every other state it is ignored and busy_o is high. At most one of busy_o, ok_o and err_o is high at a time.
- R10: After system reset, target reset and select are high, the serial clock and MOSI are low, busy_o, ok_o and err_o are low, and err_code_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a configuration run |
| partial_i | input | 1 | Partial reconfiguration request, sampled with start |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Block accepts an image byte this cycle |
| tgt_done_i | input | 1 | Target done flag, asynchronous |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_ss_n_o | output | 1 | Target SPI select, active low |
| tgt_sck_o | output | 1 | SPI serial clock |
| tgt_mosi_o | output | 1 | SPI serial data to target |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last run completed successfully |
| err_o | output | 1 | Last run ended in error |
| err_code_o | output | 2 | 0 none, 1 reset stuck, 2 not done, 3 partial refused |

## Verification
The checker assumes the done flag may change at any time and only sees it through the synchronizer. For that reason, no property ties done to a fixed cycle; the properties cover pin ordering and status exclusivity. The bench's target model holds done low before a good run and raises it only after the last byte has been accepted, or holds it high throughout for the reset-stuck case. The byte source changes valid, data and last only on falling clock edges, and drops valid right after each accepted byte.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_CHECK_LOW,
    ST_HOUSEKEEP,
    ST_STREAM,
    ST_CHECK_DONE,
    ST_PAD,
    ST_OK,
    ST_ERROR
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_RESET_STUCK = 2'd1,
    ERR_NOT_DONE    = 2'd2,
    ERR_PARTIAL     = 2'd3
  } cfg_err_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

  logic          busy;
  logic          sck;
  logic          mosi;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      sh   <= '0;
      bitn <= '0;
      hcnt <= '0;
    end else if (!busy) begin
      if (load_i) begin
        busy <= 1'b1;
        sh   <= byte_i;
        mosi <= byte_i[7];
        bitn <= '0;
        hcnt <= '0;
        sck  <= 1'b0;
      end
    end else if (hcnt == HLAST) begin
      hcnt <= '0;
      if (!sck) begin
        sck <= 1'b1;
      end else begin
        sck <= 1'b0;
        if (bitn == 3'd7) begin
          busy <= 1'b0;
          mosi <= 1'b0;
        end else begin
          bitn <= bitn + 3'd1;
          sh   <= {sh[6:0], 1'b0};
          mosi <= sh[6];
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign idle_o = !busy;
  assign sck_o  = sck;
  assign mosi_o = mosi;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RST_US      = 1,
  parameter int HK_US       = 1200,
  parameter int SCK_HALF    = 2,
  parameter int CHK_CYC     = 4,
  parameter int PAD_BYTES   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       tgt_done_i,
  output logic       tgt_rst_n_o,
  output logic       tgt_ss_n_o,
  output logic       tgt_sck_o,
  output logic       tgt_mosi_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int RST_CYC    = CYC_PER_US * RST_US;
  localparam int HK_CYC     = CYC_PER_US * HK_US;
  localparam int GAP_CYC    = 2 * SCK_HALF;
  localparam int SCK_HZ     = CLK_HZ / (2 * SCK_HALF);
  localparam int MAX_A      = (RST_CYC > HK_CYC) ? RST_CYC : HK_CYC;
  localparam int MAX_B      = (CHK_CYC > GAP_CYC) ? CHK_CYC : GAP_CYC;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int PW         = $clog2(PAD_BYTES + 1);

  if (SCK_HZ < 1_000_000 || SCK_HZ > 25_000_000) begin : g_bad_sck
    $error("cfg_loader: serial clock rate outside 1..25 MHz");
  end
  if (RST_CYC < 1 || HK_CYC < 1 || CHK_CYC < SYNC_STAGES) begin : g_bad_delay
    $error("cfg_loader: delay parameters too small");
  end

  cfg_state_e    state_q, state_d;
  cfg_err_e      code_q, code_d;
  logic          last_q, last_d;
  logic          sel_q, sel_d;
  logic [PW-1:0] pad_q, pad_d;

  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_exp;
  logic          done_s;
  logic          tx_load;
  logic [7:0]    tx_byte;
  logic          tx_idle;

  logic rst_n_q, ss_n_q, busy_q, ok_q, err_q;

  cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (tgt_done_i),
    .q_o (done_s)
  );

  cfg_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (t_load),
    .val_i     (t_val),
    .expired_o (t_exp)
  );

  cfg_spi_tx #(.HALF(SCK_HALF)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load_i (tx_load),
    .byte_i (tx_byte),
    .idle_o (tx_idle),
    .sck_o  (tgt_sck_o),
    .mosi_o (tgt_mosi_o)
  );

  assign s_ready_o = (state_q == ST_STREAM) && t_exp && tx_idle && !last_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    last_d  = last_q;
    sel_d   = sel_q;
    pad_d   = pad_q;
    t_load  = 1'b0;
    t_val   = '0;
    tx_load = 1'b0;
    tx_byte = s_data_i;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_ERROR: begin
        if (start_i) begin
          if (partial_i) begin
            state_d = ST_ERROR;
            code_d  = ERR_PARTIAL;
          end else begin
            state_d = ST_RESET;
            code_d  = ERR_NONE;
            t_load  = 1'b1;
            t_val   = TW'(RST_CYC - 1);
          end
        end
      end
      ST_RESET: begin
        if (t_exp) begin
          state_d = ST_CHECK_LOW;
          t_load  = 1'b1;
          t_val   = TW'(CHK_CYC - 1);
        end
      end
      ST_CHECK_LOW: begin
        if (t_exp) begin
          if (done_s) begin
            state_d = ST_ERROR;
            code_d  = ERR_RESET_STUCK;
          end else begin
            state_d = ST_HOUSEKEEP;
            t_load  = 1'b1;
            t_val   = TW'(HK_CYC - 1);
          end
        end
      end
      ST_HOUSEKEEP: begin
        if (t_exp) begin
          state_d = ST_STREAM;
          last_d  = 1'b0;
          t_load  = 1'b1;
          t_val   = TW'(GAP_CYC - 1);
        end
      end
      ST_STREAM: begin
        if (s_ready_o && s_valid_i) begin
          tx_load = 1'b1;
          sel_d   = 1'b1;
          if (s_last_i) last_d = 1'b1;
        end else if (last_q && tx_idle) begin
          state_d = ST_CHECK_DONE;
          sel_d   = 1'b0;
          t_load  = 1'b1;
          t_val   = TW'(CHK_CYC - 1);
        end
      end
      ST_CHECK_DONE: begin
        if (t_exp) begin
          if (done_s) begin
            state_d = ST_PAD;
            pad_d   = PW'(PAD_BYTES);
          end else begin
            state_d = ST_ERROR;
            code_d  = ERR_NOT_DONE;
          end
        end
      end
      ST_PAD: begin
        if (tx_idle) begin
          if (pad_q != '0) begin
            tx_load = 1'b1;
            tx_byte = 8'h00;
            sel_d   = 1'b1;
            pad_d   = pad_q - 1'b1;
          end else begin
            state_d = ST_OK;
            sel_d   = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      last_q  <= 1'b0;
      sel_q   <= 1'b0;
      pad_q   <= '0;
      rst_n_q <= 1'b1;
      ss_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      last_q  <= last_d;
      sel_q   <= sel_d;
      pad_q   <= pad_d;
      rst_n_q <= (state_d != ST_RESET);
      ss_n_q  <= !((state_d == ST_RESET) || (state_d == ST_CHECK_LOW) ||
                   (state_d == ST_HOUSEKEEP) || sel_d);
      busy_q  <= !((state_d == ST_IDLE) || (state_d == ST_OK) ||
                   (state_d == ST_ERROR));
      ok_q    <= (state_d == ST_OK);
      err_q   <= (state_d == ST_ERROR);
    end
  end

  assign tgt_rst_n_o = rst_n_q;
  assign tgt_ss_n_o  = ss_n_q;
  assign busy_o      = busy_q;
  assign ok_o        = ok_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_ready_o,
  input logic       tgt_rst_n_o,
  input logic       tgt_ss_n_o,
  input logic       tgt_sck_o,
  input logic       tgt_mosi_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  // R1: reset low only together with select low
  a_r1_reset_with_select: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n_o |-> !tgt_ss_n_o);

  // R2: no serial clock while target is held in reset
  a_r2_no_sck_in_reset: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n_o |-> !tgt_sck_o);

  // R4: clock only with select low
  a_r4_sck_needs_select: assert property (@(posedge clk) disable iff (rst)
    tgt_sck_o |-> !tgt_ss_n_o);

  // R4: data held while clock stays high
  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (tgt_sck_o && $past(tgt_sck_o)) |-> $stable(tgt_mosi_o));

  // R5: ready only during a run
  a_r5_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> busy_o);

  // R9: status lines mutually exclusive
  a_r9_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({busy_o, ok_o, err_o}) <= 1);

  // R8: error carries a nonzero code
  a_r8_code_with_err: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (err_code_o != 2'd0));

  // R7: success carries code zero
  a_r7_ok_code_zero: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> (err_code_o == 2'd0));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_ready_o   (s_ready_o),
  .tgt_rst_n_o (tgt_rst_n_o),
  .tgt_ss_n_o  (tgt_ss_n_o),
  .tgt_sck_o   (tgt_sck_o),
  .tgt_mosi_o  (tgt_mosi_o),
  .busy_o      (busy_o),
  .ok_o        (ok_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  localparam int RST_CYC = 50;
  localparam int HK_CYC  = 1000;
  localparam int PADB    = 7;
  localparam int HALF    = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       partial = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       tgt_done = 1'b0;
  logic       rst_n, ss_n, sck, mosi;
  logic       busy, ok, err;
  logic [1:0] code;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  cfg_loader #(
    .CLK_HZ(50_000_000), .RST_US(1), .HK_US(20), .SCK_HALF(HALF),
    .CHK_CYC(4), .PAD_BYTES(PADB), .SYNC_STAGES(2)
  ) u_cfg_loader (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last),
    .s_ready_o(s_ready), .tgt_done_i(tgt_done),
    .tgt_rst_n_o(rst_n), .tgt_ss_n_o(ss_n), .tgt_sck_o(sck),
    .tgt_mosi_o(mosi), .busy_o(busy), .ok_o(ok), .err_o(err),
    .err_code_o(code)
  );

  // pin monitors
  int   cur_lo = 0, last_lo = 0, rst_falls = 0, ss_falls = 0;
  int   rst_no_ss = 0, hk_cur = 0, last_hk = 0, sck_in_hk = 0;
  int   hi_cur = 0, last_hi = 0, nbits = 0, sck_total = 0;
  bit   in_hk = 1'b0, prev_rst_n = 1'b1, prev_ss_n = 1'b1;
  logic [7:0] cap_sh = '0;
  logic [7:0] cap [0:63];

  always @(negedge clk) begin
    if (!rst_n) cur_lo++;
    else if (cur_lo != 0) begin last_lo = cur_lo; cur_lo = 0; end
    if (!rst_n && prev_rst_n) rst_falls++;
    if (!ss_n && prev_ss_n) ss_falls++;
    if (!rst_n && ss_n) rst_no_ss++;
    if (rst_n && !prev_rst_n) begin in_hk = 1'b1; hk_cur = 0; end
    if (in_hk) begin
      if (!ss_n) hk_cur++;
      else begin in_hk = 1'b0; last_hk = hk_cur; end
    end
    if (sck) hi_cur++;
    else if (hi_cur != 0) begin last_hi = hi_cur; hi_cur = 0; end
    prev_rst_n = rst_n;
    prev_ss_n  = ss_n;
  end

  always @(posedge sck) begin
    sck_total++;
    if (in_hk) sck_in_hk++;
    if (!ss_n) begin
      cap_sh = {cap_sh[6:0], mosi};
      nbits++;
      if (nbits % 8 == 0) cap[(nbits / 8 - 1) % 64] = cap_sh;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start = 1'b1; partial = part;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit last);
    @(negedge clk);
    s_valid = 1'b1; s_data = b; s_last = last;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_end();
    int guard = 0;
    while (!(ok || err) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // R10
  task automatic t_reset();
    chk(rst_n == 1'b1, "R10 tgt_rst_n", rst_n, 1);
    chk(ss_n == 1'b1, "R10 tgt_ss_n", ss_n, 1);
    chk(sck == 1'b0 && mosi == 1'b0, "R10 sck/mosi", {sck, mosi}, 0);
    chk({busy, ok, err} == 3'b000, "R10 status", {busy, ok, err}, 0);
    chk(code == 2'd0 && s_ready == 1'b0, "R10 code/ready", code, 0);
  endtask

  task automatic t_good(input int n, input bit poke);
    logic [7:0] pat [0:7];
    int b_bits = nbits, b_rf = rst_falls, first;
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h00;
    pat[4] = 8'h81; pat[5] = 8'h5A; pat[6] = 8'h12; pat[7] = 8'hC3;
    tgt_done = 1'b0;
    pulse_start(1'b0);
    if (poke) begin
      repeat (100) @(negedge clk);
      pulse_start(1'b0);                       // R9 ignored while busy
      chk(busy == 1'b1, "R9 busy after ignored start", busy, 1);
    end
    for (int i = 0; i < n; i++) send(pat[i], i == n - 1);
    tgt_done = 1'b1;
    wait_end();
    chk(ok == 1'b1 && err == 1'b0, "R7 ok", {ok, err}, 2);
    chk(code == 2'd0, "R7 code", code, 0);
    chk(last_lo >= RST_CYC, "R1 reset length", last_lo, RST_CYC);
    chk(rst_no_ss == 0, "R1 reset without select", rst_no_ss, 0);
    chk(last_hk >= HK_CYC, "R3 housekeeping length", last_hk, HK_CYC);
    chk(sck_in_hk == 0, "R3 clock before select release", sck_in_hk, 0);
    chk(last_hi == HALF, "R4 clock high phase", last_hi, HALF);
    chk(nbits - b_bits == 8 * (n + PADB), "R7 total bits", nbits - b_bits, 8 * (n + PADB));
    chk(rst_falls - b_rf == 1, "R9 single reset pulse", rst_falls - b_rf, 1);
    first = b_bits / 8;
    for (int i = 0; i < n; i++)
      chk(cap[(first + i) % 64] == pat[i], "R5 byte MSB first", cap[(first + i) % 64], pat[i]);
    for (int i = 0; i < PADB; i++)
      chk(cap[(first + n + i) % 64] == 8'h00, "R7 pad byte zero", cap[(first + n + i) % 64], 0);
    @(negedge clk);
    chk(ss_n == 1'b1 && sck == 1'b0, "R4 idle after run", {ss_n, sck}, 2);
  endtask

  task automatic t_rstfail();
    int b_sck = sck_total;
    tgt_done = 1'b1;
    pulse_start(1'b0);
    wait_end();
    chk(err == 1'b1 && code == 2'd1, "R2 reset stuck code", code, 1);
    chk(sck_total == b_sck, "R2 no clocks", sck_total - b_sck, 0);
    chk(ss_n == 1'b1 && rst_n == 1'b1, "R2 pins released", {ss_n, rst_n}, 3);
    chk(last_lo >= RST_CYC, "R1 reset length", last_lo, RST_CYC);
  endtask

  task automatic t_notdone();
    int b_bits = nbits;
    tgt_done = 1'b0;
    pulse_start(1'b0);
    send(8'h96, 1'b0);
    send(8'h69, 1'b1);
    wait_end();
    chk(err == 1'b1 && code == 2'd2, "R6 not-done code", code, 2);
    chk(nbits - b_bits == 16, "R6 no padding", nbits - b_bits, 16);
    chk(ss_n == 1'b1, "R6 select released", ss_n, 1);
  endtask

  task automatic t_partial();
    int b_rf = rst_falls, b_sf = ss_falls;
    pulse_start(1'b1);
    repeat (20) @(negedge clk);
    chk(err == 1'b1 && code == 2'd3, "R8 partial code", code, 3);
    chk(rst_falls == b_rf, "R8 reset untouched", rst_falls - b_rf, 0);
    chk(ss_falls == b_sf, "R8 select untouched", ss_falls - b_sf, 0);
    chk(busy == 1'b0, "R8 not busy", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good(5, 1'b1);
    t_rstfail();
    t_good(3, 1'b0);      // R9 restart from error
    t_notdone();
    t_partial();
    t_good(8, 1'b0);      // R9 restart after partial refusal
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule